// File: doc/BRIEF.md
# SDRAM Column Burst Sequencer

This unit turns decoded column commands for a four-bank synchronous DRAM into a stream of per-beat column addresses. A READ or WRITE names a bank and a starting column. The unit then puts out one column per clock for the programmed burst length. The beats follow a sequential or interleaved wrap order, or a full-page walk that wraps at the end of the row. Each beat carries its bank, its direction and the byte-lane mask that was sampled with it.

Read beats also enter a short delay line. A read-data-valid strobe and its lane mask come out after the programmed read latency. A BURST STOP, or a PRECHARGE aimed at the bank being bursted, cuts the burst short. A new READ or WRITE replaces it at once. A mode-set command loads the burst parameters, but only while the unit is idle.

Top module: `sdram_burst_seq`

## Requirements
- R1: A READ (cmd 1) or WRITE (cmd 2) sampled on a rising edge puts its starting column, its bank and its direction (col_write high for WRITE) on the column outputs right after that edge. Each later edge of the burst gives one further beat.
- R2: On a mode set (cmd 5), cmd_col[2:0] selects the burst length: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8, and 4 to 7 give a full page. After reset the mode is 1 beat, sequential, latency 2.
- R3: In sequential order, the column bits below the burst length count upward from the start and wrap inside the aligned block. The upper bits stay fixed.
- R4: When cmd_col[3] of the mode is set, the low column bits are the start bits XORed with the beat index. A full-page burst ignores this bit and always counts up.
- R5: A full-page burst steps through every column, wraps from the top column to column 0, and runs until something terminates it.
- R6: cmd_col[4] of the mode selects read latency 3, and clear selects 2. Each read beat raises rd_valid for one cycle, latency cycles after the edge that sampled it. Write beats never raise rd_valid.
- R7: A READ or WRITE that arrives during a burst aborts it. The new burst's first beat follows on the next edge.
- R8: A BURST STOP (cmd 3) issues no beat on the edge that samples it and ends the burst. Read beats issued earlier still produce their rd_valid.
- R9: A PRECHARGE (cmd 4) ends the burst only when cmd_bank equals the bursting bank. A PRECHARGE to another bank has no effect on the beats.
- R10: col_mask shows the dqm value sampled with each beat. rd_mask carries a read beat's mask alongside its rd_valid.
- R11: A mode set is ignored while beats are still pending, a beat is on the outputs, or read data is in flight. The burst in progress is not disturbed by it.
- R12: After reset col_valid, rd_valid, col_mask and rd_mask are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 3 | 0 idle, 1 read, 2 write, 3 burst stop, 4 precharge, 5 mode set |
| cmd_bank | input | 2 | Bank of the command |
| cmd_col | input | 8 | Start column, or mode field on a mode set |
| dqm | input | 2 | Byte-lane mask, bit 0 lower byte, bit 1 upper byte |
| col_valid | output | 1 | A beat is issued this cycle |
| col_bank | output | 2 | Bank of the beat |
| col_addr | output | 8 | Column of the beat |
| col_write | output | 1 | Beat belongs to a write burst |
| col_mask | output | 2 | Lane mask of the beat |
| rd_valid | output | 1 | Read data beat due this cycle |
| rd_mask | output | 2 | Lane mask of that read beat |

## Verification
A command sampled on one edge shows its first column after that edge, so the bench checks beat k of a burst at the k-th falling edge after it drove the command. For read latency L, the matching rd_valid is due at falling edge L+1 through L+n, and the bench expects it low at every other falling edge in the window. Termination, interruption and ignored mode sets are judged by counting issued beats over a fixed window of falling edges after the command.

// File: rtl/sdb_pkg.sv
package sdb_pkg;

    typedef enum logic [2:0] {
        CMD_IDLE    = 3'd0,
        CMD_READ    = 3'd1,
        CMD_WRITE   = 3'd2,
        CMD_STOP    = 3'd3,
        CMD_PRECHG  = 3'd4,
        CMD_MODESET = 3'd5
    } cmd_e;

    localparam int MODE_W = 5;

    typedef struct packed {
        logic       lat3;
        logic       ilv;
        logic [2:0] len_code;
    } mode_t;

    typedef struct packed {
        logic col_cmd;
        logic wr;
        logic stop;
        logic pre;
        logic mset;
    } cmd_dec_t;

    localparam mode_t MODE_RESET = '{lat3: 1'b0, ilv: 1'b0, len_code: 3'd0};

    function automatic cmd_dec_t decode_cmd(input logic [2:0] raw);
        cmd_dec_t d;
        d = '0;
        case (cmd_e'(raw))
            CMD_READ:    d.col_cmd = 1'b1;
            CMD_WRITE:   begin d.col_cmd = 1'b1; d.wr = 1'b1; end
            CMD_STOP:    d.stop = 1'b1;
            CMD_PRECHG:  d.pre = 1'b1;
            CMD_MODESET: d.mset = 1'b1;
            default:     d = '0;
        endcase
        return d;
    endfunction

    function automatic mode_t unpack_mode(input logic [MODE_W-1:0] f);
        mode_t m;
        m.len_code = f[2:0];
        m.ilv      = f[3];
        m.lat3     = f[4];
        return m;
    endfunction

    function automatic logic is_full_page(input logic [2:0] code);
        return code[2];
    endfunction

    // low-bit wrap mask for the finite lengths
    function automatic logic [2:0] short_mask(input logic [1:0] code);
        logic [2:0] r;
        case (code)
            2'd0:    r = 3'b000;
            2'd1:    r = 3'b001;
            2'd2:    r = 3'b011;
            default: r = 3'b111;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sdb_mode_reg.sv
module sdb_mode_reg
    import sdb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mset,
    input  logic              busy,
    input  logic [MODE_W-1:0] field,
    output mode_t             mode
);

    mode_t mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_RESET;
        end else if (mset && !busy) begin
            mode_q <= unpack_mode(field);
        end
    end

    assign mode = mode_q;

    AST_MODE_HELD_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(mode_q)); // R11

endmodule

// File: rtl/sdb_col_gen.sv
module sdb_col_gen
    import sdb_pkg::*;
#(
    parameter int COL_W  = 8,
    parameter int BANK_W = 2,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              col_cmd,
    input  logic              wr_cmd,
    input  logic              stop_cmd,
    input  logic              pre_cmd,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [COL_W-1:0]  cmd_col,
    input  logic [LANES-1:0]  dqm,
    input  logic [2:0]        len_code,
    input  logic              ilv,
    output logic              col_valid,
    output logic [BANK_W-1:0] col_bank,
    output logic [COL_W-1:0]  col_addr,
    output logic              col_write,
    output logic [LANES-1:0]  col_mask,
    output logic              pending
);

    localparam logic [COL_W-1:0] ONE = COL_W'(1);

    // burst context
    logic              act_q, act_d;
    logic              wr_q, wr_d;
    logic [BANK_W-1:0] bank_q, bank_d;
    logic [COL_W-1:0]  start_q, start_d;
    logic [COL_W-1:0]  cnt_q, cnt_d;

    // beat being issued this edge
    logic              issue;
    logic [COL_W-1:0]  iss_start, iss_cnt, iss_addr;
    logic              iss_wr;
    logic [BANK_W-1:0] iss_bank;

    // output registers
    logic              v_q;
    logic [BANK_W-1:0] b_q;
    logic [COL_W-1:0]  a_q;
    logic              w_q;
    logic [LANES-1:0]  m_q;

    logic              full;
    logic [COL_W-1:0]  wmask;
    logic              last_beat;
    logic              hits_burst;

    assign full       = is_full_page(len_code);
    assign wmask      = full ? '1 : COL_W'(short_mask(len_code[1:0]));
    assign last_beat  = !full && (cnt_q == wmask);
    assign hits_burst = stop_cmd || (pre_cmd && (cmd_bank == bank_q));

    function automatic logic [COL_W-1:0] beat_col(
        input logic [COL_W-1:0] s,
        input logic [COL_W-1:0] k,
        input logic [COL_W-1:0] msk,
        input logic             xor_order
    );
        logic [COL_W-1:0] low;
        low = xor_order ? (s ^ k) : (s + k);
        return (s & ~msk) | (low & msk);
    endfunction

    always_comb begin
        act_d     = act_q;
        wr_d      = wr_q;
        bank_d    = bank_q;
        start_d   = start_q;
        cnt_d     = cnt_q;
        issue     = 1'b0;
        iss_start = start_q;
        iss_cnt   = cnt_q;
        iss_wr    = wr_q;
        iss_bank  = bank_q;
        if (col_cmd) begin
            issue     = 1'b1;
            iss_start = cmd_col;
            iss_cnt   = '0;
            iss_wr    = wr_cmd;
            iss_bank  = cmd_bank;
            start_d   = cmd_col;
            bank_d    = cmd_bank;
            wr_d      = wr_cmd;
            cnt_d     = ONE;
            act_d     = full || (wmask != '0);
        end else if (act_q && hits_burst) begin
            act_d = 1'b0;
        end else if (act_q) begin
            issue = 1'b1;
            cnt_d = cnt_q + ONE;
            if (last_beat) begin
                act_d = 1'b0;
            end
        end
    end

    assign iss_addr = beat_col(iss_start, iss_cnt, wmask, ilv && !full);

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q   <= 1'b0;
            wr_q    <= 1'b0;
            bank_q  <= '0;
            start_q <= '0;
            cnt_q   <= '0;
            v_q     <= 1'b0;
            b_q     <= '0;
            a_q     <= '0;
            w_q     <= 1'b0;
            m_q     <= '0;
        end else begin
            act_q   <= act_d;
            wr_q    <= wr_d;
            bank_q  <= bank_d;
            start_q <= start_d;
            cnt_q   <= cnt_d;
            v_q     <= issue;
            b_q     <= iss_bank;
            a_q     <= iss_addr;
            w_q     <= iss_wr;
            m_q     <= issue ? dqm : '0;
        end
    end

    assign col_valid = v_q;
    assign col_bank  = b_q;
    assign col_addr  = a_q;
    assign col_write = w_q;
    assign col_mask  = m_q;
    assign pending   = act_q;

    AST_START_BEAT: assert property (@(posedge clk) disable iff (rst)
        col_cmd |=> (v_q && a_q == $past(cmd_col) && b_q == $past(cmd_bank))); // R1

    AST_STOP_HALTS: assert property (@(posedge clk) disable iff (rst)
        (stop_cmd && !col_cmd) |=> !v_q); // R8

    AST_PRE_OWN_BANK: assert property (@(posedge clk) disable iff (rst)
        (pre_cmd && act_q && cmd_bank == bank_q) |=> !v_q); // R9

    AST_PRE_OTHER_BANK: assert property (@(posedge clk) disable iff (rst)
        (pre_cmd && act_q && cmd_bank != bank_q) |=> v_q); // R9

endmodule

// File: rtl/sdb_rd_pipe.sv
module sdb_rd_pipe #(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [LANES-1:0] in_mask,
    input  logic             lat3,
    output logic             rd_valid,
    output logic [LANES-1:0] rd_mask,
    output logic             inflight
);

    localparam int DEPTH = 3;

    logic [DEPTH-1:0] v_q;
    logic [LANES-1:0] m_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            v_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                m_q[i] <= '0;
            end
        end else begin
            v_q[0] <= in_valid;
            m_q[0] <= in_valid ? in_mask : '0;
            for (int i = 1; i < DEPTH; i++) begin
                v_q[i] <= v_q[i-1];
                m_q[i] <= m_q[i-1];
            end
        end
    end

    assign rd_valid = lat3 ? v_q[2] : v_q[1];
    assign rd_mask  = lat3 ? m_q[2] : m_q[1];
    assign inflight = |v_q;

    AST_LAT_TWO: assert property (@(posedge clk) disable iff (rst)
        (!lat3 && rd_valid) |-> $past(in_valid, 2)); // R6

    AST_LAT_THREE: assert property (@(posedge clk) disable iff (rst)
        (lat3 && rd_valid) |-> $past(in_valid, 3)); // R6

endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
    import sdb_pkg::*;
#(
    parameter int COL_W  = 8,
    parameter int BANK_W = 2,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        cmd,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [COL_W-1:0]  cmd_col,
    input  logic [LANES-1:0]  dqm,
    output logic              col_valid,
    output logic [BANK_W-1:0] col_bank,
    output logic [COL_W-1:0]  col_addr,
    output logic              col_write,
    output logic [LANES-1:0]  col_mask,
    output logic              rd_valid,
    output logic [LANES-1:0]  rd_mask
);

    cmd_dec_t dec;
    mode_t    mode;
    logic     pending;
    logic     inflight;
    logic     busy;

    assign dec  = decode_cmd(cmd);
    assign busy = pending || col_valid || inflight;

    sdb_mode_reg i_mode (
        .clk   (clk),
        .rst   (rst),
        .mset  (dec.mset),
        .busy  (busy),
        .field (cmd_col[MODE_W-1:0]),
        .mode  (mode)
    );

    sdb_col_gen #(
        .COL_W  (COL_W),
        .BANK_W (BANK_W),
        .LANES  (LANES)
    ) i_col (
        .clk       (clk),
        .rst       (rst),
        .col_cmd   (dec.col_cmd),
        .wr_cmd    (dec.wr),
        .stop_cmd  (dec.stop),
        .pre_cmd   (dec.pre),
        .cmd_bank  (cmd_bank),
        .cmd_col   (cmd_col),
        .dqm       (dqm),
        .len_code  (mode.len_code),
        .ilv       (mode.ilv),
        .col_valid (col_valid),
        .col_bank  (col_bank),
        .col_addr  (col_addr),
        .col_write (col_write),
        .col_mask  (col_mask),
        .pending   (pending)
    );

    sdb_rd_pipe #(
        .LANES (LANES)
    ) i_rd (
        .clk      (clk),
        .rst      (rst),
        .in_valid (col_valid && !col_write),
        .in_mask  (col_mask),
        .lat3     (mode.lat3),
        .rd_valid (rd_valid),
        .rd_mask  (rd_mask),
        .inflight (inflight)
    );

    AST_NO_WRITE_DATA: assert property (@(posedge clk) disable iff (rst)
        (col_valid && col_write && !pending) |=> ##2 !rd_valid || $past(busy)); // R6

endmodule

// File: tb/test_sdram_burst_seq.sv
`timescale 1ns/1ps
module test_sdram_burst_seq;

    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] cmd;
    logic [1:0] cmd_bank;
    logic [7:0] cmd_col;
    logic [1:0] dqm;
    logic       col_valid;
    logic [1:0] col_bank;
    logic [7:0] col_addr;
    logic       col_write;
    logic [1:0] col_mask;
    logic       rd_valid;
    logic [1:0] rd_mask;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    sdram_burst_seq i_sdram_burst_seq (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .cmd_bank  (cmd_bank),
        .cmd_col   (cmd_col),
        .dqm       (dqm),
        .col_valid (col_valid),
        .col_bank  (col_bank),
        .col_addr  (col_addr),
        .col_write (col_write),
        .col_mask  (col_mask),
        .rd_valid  (rd_valid),
        .rd_mask   (rd_mask)
    );

    // vector table: mode field, start column, write flag, beats, expected columns
    localparam int NV = 8;
    localparam logic [4:0] V_MODE  [NV] = '{5'd2, 5'd10, 5'd19, 5'd27, 5'd17, 5'd9, 5'd16, 5'd3};
    localparam logic [7:0] V_START [NV] = '{8'h0D, 8'h0D, 8'h25, 8'h25, 8'h33, 8'h32, 8'h47, 8'hF8};
    localparam logic       V_WR    [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0};
    localparam int         V_LEN   [NV] = '{4, 4, 8, 8, 2, 2, 1, 8};
    localparam logic [7:0] V_EXP [NV][8] = '{
        '{8'h0D, 8'h0E, 8'h0F, 8'h0C, 8'h00, 8'h00, 8'h00, 8'h00},
        '{8'h0D, 8'h0C, 8'h0F, 8'h0E, 8'h00, 8'h00, 8'h00, 8'h00},
        '{8'h25, 8'h26, 8'h27, 8'h20, 8'h21, 8'h22, 8'h23, 8'h24},
        '{8'h25, 8'h24, 8'h27, 8'h26, 8'h21, 8'h20, 8'h23, 8'h22},
        '{8'h33, 8'h32, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00},
        '{8'h32, 8'h33, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00},
        '{8'h47, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00},
        '{8'hF8, 8'hF9, 8'hFA, 8'hFB, 8'hFC, 8'hFD, 8'hFE, 8'hFF}
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] c, input logic [1:0] b, input logic [7:0] col, input logic [1:0] m);
        @(negedge clk);
        cmd = c; cmd_bank = b; cmd_col = col; dqm = m;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(3'd0, 2'd0, 8'h00, 2'b00);
    endtask

    task automatic mode_set(input logic [4:0] f);
        drive(3'd5, 2'd0, {3'b000, f}, 2'b00);
    endtask

    // counts beats and read strobes over n falling edges after a command
    task automatic count_window(input int n, output int beats, output int reads);
        beats = 0; reads = 0;
        for (int k = 1; k <= n; k++) begin
            @(negedge clk);
            cmd = 3'd0;
            if (col_valid) beats++;
            if (rd_valid) reads++;
        end
    endtask

    initial begin
        int nb, nr, lat;
        cmd = 3'd0; cmd_bank = 2'd0; cmd_col = 8'h00; dqm = 2'b00;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R12: reset state
        chk("R12", "col_valid after reset", int'(col_valid), 0);
        chk("R12", "rd_valid after reset", int'(rd_valid), 0);
        chk("R12", "col_mask after reset", int'(col_mask), 0);
        chk("R12", "rd_mask after reset", int'(rd_mask), 0);

        // R2: reset mode is 1 beat, latency 2
        drive(3'd1, 2'd2, 8'h12, 2'b00);
        for (int k = 1; k <= 4; k++) begin
            @(negedge clk);
            cmd = 3'd0;
            if (k == 1) begin
                chk("R2", "reset-mode beat valid", int'(col_valid), 1);
                chk("R1", "reset-mode beat addr", int'(col_addr), 'h12);
                chk("R1", "reset-mode beat bank", int'(col_bank), 2);
            end
            if (k == 2) chk("R2", "reset-mode single beat", int'(col_valid), 0);
            chk("R6", "reset-mode rd_valid", int'(rd_valid), (k == 3) ? 1 : 0);
        end

        // table walk: R1 R2 R3 R4 R6
        for (int v = 0; v < NV; v++) begin
            idle(6);
            mode_set(V_MODE[v]);
            lat = V_MODE[v][4] ? 3 : 2;
            drive(V_WR[v] ? 3'd2 : 3'd1, 2'(v), V_START[v], 2'b00);
            for (int k = 1; k <= V_LEN[v] + lat + 1; k++) begin
                @(negedge clk);
                cmd = 3'd0;
                if (k <= V_LEN[v]) begin
                    chk("R3/R4", $sformatf("vec %0d beat %0d addr", v, k - 1), int'(col_addr), int'(V_EXP[v][k-1]));
                    chk("R1", $sformatf("vec %0d beat %0d valid", v, k - 1), int'(col_valid), 1);
                    chk("R1", $sformatf("vec %0d beat %0d bank", v, k - 1), int'(col_bank), v % 4);
                    chk("R1", $sformatf("vec %0d beat %0d dir", v, k - 1), int'(col_write), int'(V_WR[v]));
                end else if (k == V_LEN[v] + 1) begin
                    chk("R2", $sformatf("vec %0d burst end", v), int'(col_valid), 0);
                end
                chk("R6", $sformatf("vec %0d rd_valid at %0d", v, k), int'(rd_valid),
                    (!V_WR[v] && k >= lat + 1 && k <= lat + V_LEN[v]) ? 1 : 0);
            end
        end

        // R5 R4 R8: full page, interleave bit set but ignored, stop after 10 beats
        idle(6);
        mode_set(5'd13);
        drive(3'd1, 2'd1, 8'hFA, 2'b00);
        nr = 0;
        for (int k = 1; k <= 14; k++) begin
            @(negedge clk);
            cmd = 3'd0;
            if (rd_valid) nr++;
            if (k <= 10) chk("R5", $sformatf("full page beat %0d", k - 1), int'(col_addr), (8'hFA + k - 1) % 256);
            if (k == 10) cmd = 3'd3;
            if (k == 11 || k == 12) chk("R8", "no beat after stop", int'(col_valid), 0);
        end
        chk("R8", "reads delivered after stop", nr, 10);

        // R9: precharge to another bank is ignored, to own bank stops
        idle(6);
        mode_set(5'd3);
        drive(3'd2, 2'd1, 8'h10, 2'b00);
        @(negedge clk);
        chk("R9", "first beat", int'(col_addr), 'h10);
        cmd = 3'd4; cmd_bank = 2'd2;
        @(negedge clk);
        chk("R9", "other-bank precharge keeps beat", int'(col_valid), 1);
        chk("R9", "other-bank precharge addr", int'(col_addr), 'h11);
        cmd = 3'd4; cmd_bank = 2'd1;
        @(negedge clk);
        cmd = 3'd0;
        chk("R9", "own-bank precharge stops", int'(col_valid), 0);
        @(negedge clk);
        chk("R9", "stays stopped", int'(col_valid), 0);

        // R7: interrupt a read with a write
        idle(6);
        drive(3'd1, 2'd0, 8'h40, 2'b00);
        @(negedge clk);
        cmd = 3'd0;
        @(negedge clk);
        chk("R7", "second beat before interrupt", int'(col_addr), 'h41);
        cmd = 3'd2; cmd_bank = 2'd3; cmd_col = 8'h80;
        @(negedge clk);
        cmd = 3'd0;
        chk("R7", "new burst addr", int'(col_addr), 'h80);
        chk("R7", "new burst bank", int'(col_bank), 3);
        chk("R7", "new burst dir", int'(col_write), 1);
        @(negedge clk);
        chk("R7", "new burst continues", int'(col_addr), 'h81);

        // R11: mode set during a burst is ignored
        idle(12);
        drive(3'd1, 2'd0, 8'h00, 2'b00);
        @(negedge clk);
        cmd = 3'd5; cmd_col = 8'h01;
        count_window(12, nb, nr);
        chk("R11", "beats with ignored mode set", nb + 1, 8);
        idle(6);
        drive(3'd1, 2'd0, 8'h08, 2'b00);
        count_window(12, nb, nr);
        chk("R11", "mode unchanged afterwards", nb, 8);
        idle(6);
        mode_set(5'd1);
        drive(3'd1, 2'd0, 8'h08, 2'b00);
        count_window(8, nb, nr);
        chk("R11", "idle mode set takes effect", nb, 2);

        // R10: per-beat write masks and read masks
        idle(6);
        mode_set(5'd2);
        drive(3'd2, 2'd0, 8'h00, 2'b01);
        @(negedge clk);
        cmd = 3'd0;
        chk("R10", "write beat 0 mask", int'(col_mask), 1);
        dqm = 2'b10;
        @(negedge clk);
        chk("R10", "write beat 1 mask", int'(col_mask), 2);
        dqm = 2'b11;
        @(negedge clk);
        chk("R10", "write beat 2 mask", int'(col_mask), 3);
        idle(8);
        drive(3'd1, 2'd0, 8'h00, 2'b10);
        @(negedge clk);
        cmd = 3'd0; dqm = 2'b01;
        @(negedge clk);
        dqm = 2'b00;
        @(negedge clk);
        chk("R10", "read beat 0 rd_mask", int'(rd_mask), 2);
        chk("R10", "read beat 0 rd_valid", int'(rd_valid), 1);
        @(negedge clk);
        chk("R10", "read beat 1 rd_mask", int'(rd_mask), 1);
        idle(6);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
        $finish;
    end

endmodule